// File: doc/BRIEF.md
# USB Device Global Control Sequencer

This block owns the top-level control and status byte of a full-speed USB device controller and the small amount of bus-state logic that the byte depends on. The CPU writes and reads the byte through a one-cycle write strobe and a continuously driven read bus. From decoded line states and a 12 MHz bit-rate tick, the block works out three things: when the bus has gone quiet, when the host is resetting the device, and when the device may signal a remote wakeup. It also drives the transceiver enable, the controller clock enables, the resume K-drive output and the effective function address seen by the packet engine.

All durations are counted in bit-rate ticks. A span counter measures each one, and its count returns to zero on any clock cycle in which its qualifying condition is false. The defaults give 3 ms of idle before suspend, 32 bit times of SE0 for a bus reset, 5 ms of suspend before a wakeup may start, and 10 ms of K drive. A bench can shorten all four by parameter.

The bus state machine has three states. BUS_ACTIVE is the normal state, and the machine moves to BUS_SUSPEND once the idle span completes. From BUS_SUSPEND, a K or SE0 on the line returns it to BUS_ACTIVE, and a qualified wakeup moves it to BUS_RESUME. BUS_RESUME drives K and moves back to BUS_ACTIVE when the resume span completes. Whenever the enable bit is clear, the machine is forced to BUS_ACTIVE.

Top module: `usb_gctl_seq`

## Requirements
- R1: The control byte reads as {enable[7], clock-stop[6], wake-request[5], reserved[4], resume-status[3], wake-enable[2], configured[1], address-valid[0]}. After reset it reads 0x00. A CPU write takes effect on the next clock.
- R2: While enable (bit 7) is clear, `xcvr_en`, `clk_en`, `clk48_en`, `drive_k`, `suspended` and `bus_reset` are low, the state machine is held in BUS_ACTIVE, and bit 3 reads 0.
- R3: While clock-stop (bit 6) is set, `clk48_en` is low. Leaving suspend on a K still works while this bit is set.
- R4: BUS_RESUME is entered only from BUS_SUSPEND, and only when all of the following hold: bit 3 is set, bits 5 and 2 are set, bit 6 is clear, and the machine has been in BUS_SUSPEND for at least DWELL_TICKS ticks.
- R5: Bit 3 is set by hardware one clock after the condition "bits 7, 5 and 2 all set" becomes true. It stays clear if bit 2 is clear. CPU writes to bit 3 have no effect.
- R6: Hardware never clears wake-request (bit 5). It is still set after a completed resume.
- R7: SE0 held for RST_TICKS ticks raises `bus_reset`. While `bus_reset` is high, bits 1 and 0 are cleared, and this clearing takes priority over a CPU write in the same cycle.
- R8: `func_addr` equals `prog_addr` while bit 0 is set, and 0 otherwise.
- R9: Bit 4 always reads 0, and writes to it are ignored.
- R10: BUS_SUSPEND is entered after IDLE_TICKS ticks of continuous J. It is left on the clock after a K or SE0 is seen. `suspended` is high in that state.
- R11: In BUS_RESUME, `drive_k` is high for RESUME_TICKS ticks. The machine then returns to BUS_ACTIVE, and bit 3 clears on the same clock.
- R12: Any interruption of the qualifying line state restarts a span. For example, SE0 shorter than RST_TICKS, or J broken by a K before IDLE_TICKS, leaves the block's state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low hardware reset |
| wr_en | input | 1 | CPU write strobe for the control byte |
| wr_data | input | 8 | CPU write data |
| rd_data | output | 8 | Control byte as read by the CPU |
| tick_12m | input | 1 | One-cycle pulse per full-speed bit time |
| line_se0 | input | 1 | Decoded line state SE0 |
| line_j | input | 1 | Decoded line state J (idle) |
| line_k | input | 1 | Decoded line state K |
| prog_addr | input | 7 | Function address programmed by firmware |
| func_addr | output | 7 | Effective function address |
| xcvr_en | output | 1 | Transceiver enable |
| clk_en | output | 1 | Controller core clock enable |
| clk48_en | output | 1 | 48 MHz clock enable |
| drive_k | output | 1 | Drive K upstream for resume signalling |
| suspended | output | 1 | Bus is in suspend |
| bus_reset | output | 1 | Bus reset detected (level while SE0 persists) |

## Verification
The hardest state to reach from the ports is the start of a remote wakeup. It needs four conditions at once: the machine sitting in suspend, the status bit armed by a fresh rise of the request condition, the clock-stop bit clear, and the dwell span completed. The stimulus first holds J until suspend is entered. It then arms the wakeup with clock-stop set and waits well past the dwell, confirming that no K is driven. Finally it clears clock-stop, so the resume begins on a known clock. A second pass arms the wakeup right after suspend is entered, to show that the dwell span gates the start.

// File: rtl/usb_gctl_pkg.sv
package usb_gctl_pkg;

    typedef enum logic [1:0] {
        BUS_ACTIVE  = 2'd0,
        BUS_SUSPEND = 2'd1,
        BUS_RESUME  = 2'd2
    } bus_state_t;

    // Bit positions of the control byte (software-visible layout)
    localparam int B_EN       = 7;
    localparam int B_CLKSTOP  = 6;
    localparam int B_WAKE_REQ = 5;
    localparam int B_RSV      = 4;
    localparam int B_RSM      = 3;
    localparam int B_WAKE_EN  = 2;
    localparam int B_CFG      = 1;
    localparam int B_ADDR_OK  = 0;

    // Bits the CPU may write; reserved and status bits excluded
    localparam logic [7:0] CPU_WR_MASK = 8'b1110_0111;

endpackage

// File: rtl/usb_gctl_span.sv
module usb_gctl_span #(
    parameter int LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    input  logic tick,
    output logic reached
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    // Counts ticks while cond holds; any break reloads to zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!cond) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != LIM)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign reached = (cnt_q == LIM);
endmodule

// File: rtl/usb_gctl_regs.sv
module usb_gctl_regs
    import usb_gctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       bus_rst,
    input  logic       resume_done,
    output logic [7:0] ctrl
);
    logic [7:0] cfg_q;
    logic       rsm_q;
    logic       arm_q;
    logic       arm;

    assign arm = cfg_q[B_EN] & cfg_q[B_WAKE_REQ] & cfg_q[B_WAKE_EN];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            rsm_q <= 1'b0;
            arm_q <= 1'b0;
        end else begin
            if (wr_en) begin
                cfg_q <= wr_data & CPU_WR_MASK;
            end
            if (bus_rst) begin
                cfg_q[B_CFG]     <= 1'b0;
                cfg_q[B_ADDR_OK] <= 1'b0;
            end
            arm_q <= arm;
            if (!cfg_q[B_EN] || resume_done) begin
                rsm_q <= 1'b0;
            end else if (arm && !arm_q) begin
                rsm_q <= 1'b1;
            end
        end
    end

    // cfg_q[4:3] are masked on write and stay zero
    assign ctrl = {cfg_q[B_EN], cfg_q[B_CLKSTOP], cfg_q[B_WAKE_REQ], cfg_q[B_RSV],
                   cfg_q[B_RSM] | (rsm_q & cfg_q[B_EN]),
                   cfg_q[B_WAKE_EN], cfg_q[B_CFG], cfg_q[B_ADDR_OK]};
endmodule

// File: rtl/usb_gctl_seq.sv
module usb_gctl_seq
    import usb_gctl_pkg::*;
#(
    parameter int IDLE_TICKS   = 36000,
    parameter int RST_TICKS    = 32,
    parameter int DWELL_TICKS  = 60000,
    parameter int RESUME_TICKS = 120000,
    parameter int ADDR_W       = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    input  logic              tick_12m,
    input  logic              line_se0,
    input  logic              line_j,
    input  logic              line_k,
    input  logic [ADDR_W-1:0] prog_addr,
    output logic [ADDR_W-1:0] func_addr,
    output logic              xcvr_en,
    output logic              clk_en,
    output logic              clk48_en,
    output logic              drive_k,
    output logic              suspended,
    output logic              bus_reset
);
    bus_state_t state_q, state_d;
    logic [7:0] ctrl;
    logic       ctl_en;
    logic       idle_hit, rst_hit, dwell_hit, res_hit;
    logic       wake_go, resume_done, bus_rst_int;

    assign ctl_en      = ctrl[B_EN];
    assign bus_rst_int = ctl_en & rst_hit;
    assign resume_done = (state_q == BUS_RESUME) & res_hit;
    assign wake_go     = ctrl[B_RSM] & ctrl[B_WAKE_REQ] & ctrl[B_WAKE_EN]
                       & ~ctrl[B_CLKSTOP] & dwell_hit;

    usb_gctl_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .bus_rst     (bus_rst_int),
        .resume_done (resume_done),
        .ctrl        (ctrl)
    );

    usb_gctl_span #(.LIMIT(IDLE_TICKS)) u_idle (
        .clk(clk), .rst_n(rst_n), .tick(tick_12m),
        .cond(ctl_en && state_q == BUS_ACTIVE && line_j), .reached(idle_hit));

    usb_gctl_span #(.LIMIT(RST_TICKS)) u_se0 (
        .clk(clk), .rst_n(rst_n), .tick(tick_12m),
        .cond(ctl_en && line_se0), .reached(rst_hit));

    usb_gctl_span #(.LIMIT(DWELL_TICKS)) u_dwell (
        .clk(clk), .rst_n(rst_n), .tick(tick_12m),
        .cond(state_q == BUS_SUSPEND), .reached(dwell_hit));

    usb_gctl_span #(.LIMIT(RESUME_TICKS)) u_kdrv (
        .clk(clk), .rst_n(rst_n), .tick(tick_12m),
        .cond(state_q == BUS_RESUME), .reached(res_hit));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_ACTIVE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!ctl_en) begin
            state_d = BUS_ACTIVE;
        end else begin
            unique case (state_q)
                BUS_ACTIVE:  if (idle_hit) state_d = BUS_SUSPEND;
                BUS_SUSPEND: begin
                    if (line_k || line_se0) state_d = BUS_ACTIVE;
                    else if (wake_go)       state_d = BUS_RESUME;
                end
                BUS_RESUME:  if (res_hit) state_d = BUS_ACTIVE;
                default:     state_d = BUS_ACTIVE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        rd_data   = ctrl;
        func_addr = ctrl[B_ADDR_OK] ? prog_addr : '0;
        xcvr_en   = ctl_en;
        clk_en    = ctl_en;
        clk48_en  = ctl_en & ~ctrl[B_CLKSTOP];
        drive_k   = ctl_en & (state_q == BUS_RESUME);
        suspended = ctl_en & (state_q == BUS_SUSPEND);
        bus_reset = bus_rst_int;
    end
endmodule

// File: rtl/usb_gctl_seq_chk.sv
module usb_gctl_seq_chk #(
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        rd_data,
    input logic [ADDR_W-1:0] func_addr,
    input logic              xcvr_en,
    input logic              clk_en,
    input logic              clk48_en,
    input logic              drive_k,
    input logic              suspended,
    input logic              bus_reset
);
    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n) rd_data[4] == 1'b0); // R9
    AST_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !rd_data[0] |-> func_addr == '0); // R8
    AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[7] |-> (!xcvr_en && !clk_en && !clk48_en && !drive_k && !suspended && !bus_reset && !rd_data[3])); // R2
    AST_CLK_STOP: assert property (@(posedge clk) disable iff (!rst_n) rd_data[6] |-> !clk48_en); // R3
    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) bus_reset |=> rd_data[1:0] == 2'b00); // R7
    AST_KDRIVE_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_k) |-> $past(suspended && rd_data[3] && rd_data[5] && rd_data[2] && !rd_data[6])); // R4
    AST_KDRIVE_END: assert property (@(posedge clk) disable iff (!rst_n) $fell(drive_k) |-> !rd_data[3]); // R11
    AST_STATE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(drive_k && suspended)); // R10
endmodule

bind usb_gctl_seq usb_gctl_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .func_addr(func_addr),
    .xcvr_en(xcvr_en), .clk_en(clk_en), .clk48_en(clk48_en), .drive_k(drive_k),
    .suspended(suspended), .bus_reset(bus_reset));

// File: tb/usb_gctl_seq_tb.sv
module usb_gctl_seq_tb_top;
    localparam int CLK_P   = 10;
    localparam int IDLE_T  = 20;
    localparam int RST_T   = 32;
    localparam int DWELL_T = 30;
    localparam int RES_T   = 15;
    localparam logic [6:0] PADDR = 7'h2D;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic tick = 1'b0;
    logic se0 = 1'b0, lj = 1'b0, lk = 1'b0;
    logic [7:0] rd_data;
    logic [6:0] func_addr;
    logic xcvr_en, clk_en, clk48_en, drive_k, suspended, bus_reset;

    int n_chk = 0, n_err = 0, tk = 0;

    // behavioural model state
    logic [7:0] mreg = '0;
    bit mrsm = 0, marm = 0;
    int mst = 0, ci = 0, cr = 0, cd = 0, cs = 0;

    always #(CLK_P/2) clk = ~clk;

    usb_gctl_seq #(.IDLE_TICKS(IDLE_T), .RST_TICKS(RST_T), .DWELL_TICKS(DWELL_T),
                   .RESUME_TICKS(RES_T), .ADDR_W(7)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .tick_12m(tick), .line_se0(se0), .line_j(lj), .line_k(lk),
        .prog_addr(PADDR), .func_addr(func_addr), .xcvr_en(xcvr_en), .clk_en(clk_en),
        .clk48_en(clk48_en), .drive_k(drive_k), .suspended(suspended), .bus_reset(bus_reset));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int span(input bit c, input int cnt, input int lim);
        if (!c) return 0;
        return (tick && cnt < lim) ? cnt + 1 : cnt;
    endfunction

    // Model advance for one clock, using the inputs currently applied
    task automatic model_step();
        bit en, go, done, arm, brst;
        int nst;
        if (!rst_n) begin
            mreg = '0; mrsm = 0; marm = 0; mst = 0; ci = 0; cr = 0; cd = 0; cs = 0;
            return;
        end
        en   = mreg[7];
        brst = en && cr == RST_T;
        go   = mrsm && en && mreg[5] && mreg[2] && !mreg[6] && cd == DWELL_T;
        done = mst == 2 && cs == RES_T;
        nst  = mst;
        if (!en) nst = 0;
        else if (mst == 0 && ci == IDLE_T) nst = 1;
        else if (mst == 1 && (lk || se0)) nst = 0;
        else if (mst == 1 && go) nst = 2;
        else if (mst == 2 && cs == RES_T) nst = 0;
        ci = span(en && mst == 0 && lj, ci, IDLE_T);
        cr = span(en && se0, cr, RST_T);
        cd = span(mst == 1, cd, DWELL_T);
        cs = span(mst == 2, cs, RES_T);
        arm = en && mreg[5] && mreg[2];
        if (!en || done) mrsm = 0;
        else if (arm && !marm) mrsm = 1;
        marm = arm;
        if (wr_en) mreg = wr_data & 8'hE7;
        if (brst) mreg[1:0] = 2'b00;
        mst = nst;
    endtask

    task automatic compare();
        bit en = mreg[7];
        logic [7:0] erd = {mreg[7:4], mrsm & en, mreg[2:0]};
        chk(rd_data === erd, "R1 rd_data", rd_data, erd);
        chk(func_addr === (mreg[0] ? PADDR : 7'h0), "R8 func_addr", func_addr, mreg[0] ? PADDR : 7'h0);
        chk(xcvr_en === en && clk_en === en, "R2 enables", {xcvr_en, clk_en}, {en, en});
        chk(clk48_en === (en && !mreg[6]), "R3 clk48_en", clk48_en, en && !mreg[6]);
        chk(drive_k === (en && mst == 2), "R11 drive_k", drive_k, en && mst == 2);
        chk(suspended === (en && mst == 1), "R10 suspended", suspended, en && mst == 1);
        chk(bus_reset === (en && cr == RST_T), "R7 bus_reset", bus_reset, en && cr == RST_T);
    endtask

    task automatic cyc();
        tick = (tk % 2 == 0);
        tk++;
        model_step();
        @(posedge clk);
        #1;
        compare();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic line(input bit s, input bit j, input bit k);
        se0 = s; lj = j; lk = k;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #2;
        run(3);
        rst_n = 1'b1;
        run(2);
        chk(rd_data == 8'h00, "R1 reset value", rd_data, 8'h00);
        chk(!xcvr_en && !clk_en && !clk48_en, "R2 disabled after reset", xcvr_en, 0);

        // enable, configured, address valid; try reserved and status bits
        line(0, 0, 1);
        wr(8'h9B);
        chk(rd_data == 8'h83, "R9 R5 masked write", rd_data, 8'h83);
        chk(func_addr == PADDR, "R8 address passes", func_addr, PADDR);

        // short SE0: no reset
        line(1, 0, 0); run(20);
        line(0, 0, 1); run(4);
        chk(!bus_reset && rd_data == 8'h83, "R12 short SE0 ignored", rd_data, 8'h83);

        // long SE0: bus reset
        line(1, 0, 0); run(80);
        chk(bus_reset == 1'b1, "R7 reset seen", bus_reset, 1);
        chk(rd_data[1:0] == 2'b00, "R7 bits cleared", rd_data[1:0], 0);
        chk(func_addr == 7'h0, "R8 address zero", func_addr, 0);
        wr(8'h83);
        chk(rd_data[1:0] == 2'b00, "R7 clear beats write", rd_data[1:0], 0);
        line(0, 0, 1); run(3);
        wr(8'h83);

        // broken idle, then suspend
        line(0, 1, 0); run(30);
        line(0, 0, 1); run(2);
        line(0, 1, 0); run(30);
        chk(!suspended, "R12 broken J restarts", suspended, 0);
        run(20);
        chk(suspended, "R10 suspend entered", suspended, 1);
        line(0, 0, 1); run(2);
        chk(!suspended, "R10 K exits suspend", suspended, 0);

        // suspend with clocks stopped and wake armed
        line(0, 1, 0); run(50);
        wr(8'hE7);
        chk(!clk48_en, "R3 clk48 off", clk48_en, 0);
        run(100);
        chk(!drive_k, "R4 no resume while stopped", drive_k, 0);
        chk(rd_data[3], "R5 status set", rd_data[3], 1);
        wr(8'hA7);
        run(1);
        chk(drive_k, "R4 resume starts", drive_k, 1);
        run(20);
        chk(drive_k, "R11 K still driven", drive_k, 1);
        run(15);
        chk(!drive_k && !rd_data[3], "R11 resume ends", rd_data[3], 0);
        chk(rd_data[5], "R6 wake request kept", rd_data[5], 1);

        // dwell gating
        wr(8'h83);
        line(0, 0, 1); run(2);
        line(0, 1, 0); run(50);
        wr(8'hA7);
        run(10);
        chk(!drive_k, "R4 dwell not met", drive_k, 0);
        run(60);
        chk(drive_k, "R4 dwell met", drive_k, 1);
        run(40);

        // wake enable clear: status stays clear
        wr(8'h83);
        run(2);
        wr(8'hA3);
        run(3);
        chk(!rd_data[3], "R5 no status without enable", rd_data[3], 0);

        // resume detect with clock stopped
        wr(8'hC3);
        line(0, 1, 0); run(50);
        chk(suspended, "R3 suspend with clock stopped", suspended, 1);
        line(0, 0, 1); run(1);
        chk(!suspended, "R3 K seen with clock stopped", suspended, 0);

        // disable while suspended
        line(0, 1, 0); run(50);
        wr(8'h03);
        chk(!suspended && !xcvr_en && !clk48_en, "R2 disable", suspended, 0);
        run(5);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule